// File: doc/BRIEF.md
# Streaming Softmax Attention Row Accumulator

This block produces one output row of exact scaled dot-product attention without ever holding the row's scores or probabilities. An upstream engine computes query-key scores and delivers them one element at a time, each with the value vector that belongs to it. Start and end markers frame each row. The block keeps three pieces of running state: the largest score seen so far, a sum of base-2 exponentials taken relative to that largest score, and a weighted accumulator with one lane per value dimension. When a score exceeds the current maximum, the sum and the accumulator are scaled down to the new reference point. When a score does not exceed it, no rescale multiply takes place.

Normalization is deferred until the row ends. A bit-serial divider then divides each accumulator lane by the running sum. While it works, the input side is held not-ready. The normalized vector is presented together with the final maximum and sum, and it stays on the outputs until the consumer accepts it.

Scores are signed fixed-point values with `FRAC_W` fractional bits. Values are signed integers. Weights are unsigned Q1.15 numbers, in which 1.0 is 32768.

Top module: `osm_attn_row`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A beat with `in_sop`=1 starts a new row: it behaves as if the maximum were the most negative score and the sum and every lane were zero, so no earlier row affects the result.
- R3: `out_max` equals the largest score accepted in the current row, and it never decreases within a row.
- R4: The weight for a non-positive difference d (score units) is defined as follows. Take n=-d. The integer part is i=n>>FRAC_W. The top 3 fractional bits give the segment s, and the remaining fractional bits give the position t. Let K[k]=round(32768*2^(-k/8)) for k=0..8. Then y = K[s] - (((K[s]-K[s+1])*t) >> (FRAC_W-3)), and the weight is y>>i, or 0 when i>=16.
- R5: For a score x above the current maximum m: the sum becomes floor(sum*w/32768)+32768, each lane becomes floor(lane*w/32768)+v*32768 with w=weight(m-x), and m becomes x.
- R6: For a score x at or below m (equal counts as not new), there is no rescale: w=weight(x-m), the sum gains w and each lane gains v*w.
- R7: Output lane k equals that accumulator lane divided by the sum, truncated toward zero and kept to VAL_W bits. `out_sum` is the final sum.
- R8: `out_valid` rises exactly DIM*ACC_W clock edges after the edge that accepts the end-of-row beat. `in_ready` stays 0 from that edge until the output is accepted.
- R9: While `out_valid`=1 and `out_ready`=0, the output vector, maximum and sum hold steady.
- R10: The output agrees with a two-pass softmax (global max first, then weights) built on the same exponential, within 1/64 of the largest value magnitude plus 2. The agreement is exact when the row's first score is its maximum.
- R11: A one-element row returns its value vector unchanged, with sum 32768.
- R12: Lane k of `in_value` and `out_vec` occupies bits [k*VAL_W +: VAL_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts a beat |
| in_sop | input | 1 | First beat of a row |
| in_eop | input | 1 | Last beat of a row |
| in_score | input | SCORE_W | Signed fixed-point score |
| in_value | input | DIM*VAL_W | Value vector, lanes packed |
| out_valid | output | 1 | Normalized row available |
| out_ready | input | 1 | Consumer takes the row |
| out_vec | output | DIM*VAL_W | Normalized output vector |
| out_max | output | SCORE_W | Row maximum score |
| out_sum | output | SUM_W | Row sum of weights |

## Verification
A beat updates the running maximum at the edge that accepts it, so that state is visible on `out_max` one edge later. The normalized row appears exactly DIM*ACC_W edges after the edge that accepts the end-of-row beat. The bench counts edges with a cycle counter, records the count at the end-of-row acceptance, and compares it with the count at which `out_valid` is first seen. All sampling happens on falling edges. The checks against the exact single-pass model and against the two-pass reference are made in that first valid cycle and again after a deliberate output stall.

// File: rtl/osm_pkg.sv
// Shared types and constants for the streaming softmax row block.
// Assumes weights are unsigned Q1.15 values (1.0 = 32768).
package osm_pkg;
    localparam int          W_BITS = 16;
    localparam int          W_FRAC = 15;
    localparam logic [15:0] W_ONE  = 16'h8000;

    typedef enum logic [1:0] {ST_ACCUM, ST_DIV, ST_OUT} osm_state_e;

    // Knot k of 2^(-k/8) in Q1.15, rounded to nearest.
    function automatic logic [15:0] exp_knot(input logic [3:0] k);
        case (k)
            4'd0:    return 16'd32768;
            4'd1:    return 16'd30048;
            4'd2:    return 16'd27554;
            4'd3:    return 16'd25268;
            4'd4:    return 16'd23170;
            4'd5:    return 16'd21247;
            4'd6:    return 16'd19484;
            4'd7:    return 16'd17867;
            default: return 16'd16384;
        endcase
    endfunction
endpackage

// File: rtl/osm_exp2.sv
// Piecewise-linear 2^(-mag) in Q1.15: the integer part of mag becomes a right
// shift, and the fraction interpolates linearly between 8 knots.
// Assumes mag is a non-negative magnitude with FRAC_W > 3 fractional bits.
module osm_exp2 #(
    parameter int MAG_W  = 17,
    parameter int FRAC_W = 8
) (
    input  logic [MAG_W-1:0] mag,
    output logic [15:0]      weight
);
    import osm_pkg::*;
    localparam int SEG_SH = FRAC_W - 3;
    localparam int INT_W  = MAG_W - FRAC_W;

    logic [INT_W-1:0]     ipart;
    logic [2:0]           seg;
    logic [SEG_SH-1:0]    pos;
    logic [15:0]          lo_k, hi_k, slope, interp;
    logic [15+SEG_SH:0]   drop;

    // Split the magnitude, interpolate inside the segment, then shift by the integer part.
    always_comb begin
        ipart  = mag[MAG_W-1:FRAC_W];
        seg    = mag[FRAC_W-1:SEG_SH];
        pos    = mag[SEG_SH-1:0];
        lo_k   = exp_knot({1'b0, seg});
        hi_k   = exp_knot({1'b0, seg} + 4'd1);
        slope  = lo_k - hi_k;
        drop   = slope * pos;
        interp = lo_k - 16'(drop >> SEG_SH);
        weight = (ipart >= INT_W'(16)) ? 16'd0 : (interp >> ipart[3:0]);
    end
endmodule

// File: rtl/osm_lane_upd.sv
// Next value of one accumulator lane. On a new maximum (grow) the lane is
// scaled by w and the value enters at weight 1.0; otherwise the value enters
// at weight w and there is no scaling. Assumes ACC_W > VAL_W + 16.
module osm_lane_upd #(
    parameter int VAL_W = 16,
    parameter int ACC_W = 40
) (
    input  logic signed [ACC_W-1:0] acc_in,
    input  logic signed [VAL_W-1:0] val,
    input  logic        [15:0]      w,
    input  logic                    grow,
    output logic signed [ACC_W-1:0] acc_out
);
    import osm_pkg::*;
    logic signed [ACC_W-1:0] val_x;
    logic signed [ACC_W+16:0] scaled_p, term_p;

    // Choose between the rescale-and-add path and the plain weighted add.
    always_comb begin
        val_x    = {{(ACC_W-VAL_W){val[VAL_W-1]}}, val};
        scaled_p = acc_in * $signed({1'b0, w});
        term_p   = val_x * $signed({1'b0, w});
        if (grow)
            acc_out = ACC_W'(scaled_p >>> W_FRAC) + (val_x <<< W_FRAC);
        else
            acc_out = acc_in + ACC_W'(term_p);
    end
endmodule

// File: rtl/osm_divider.sv
// Bit-serial restoring divider. It divides every lane of num_flat by den,
// one quotient bit per cycle and lane after lane, truncating toward zero.
// Assumes den and num_flat stay constant while busy, and den > 0.
// done rises in the cycle of the final step.
module osm_divider #(
    parameter int DIM   = 4,
    parameter int ACC_W = 40,
    parameter int SUM_W = 32,
    parameter int VAL_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [DIM*ACC_W-1:0]   num_flat,
    input  logic [SUM_W-1:0]       den,
    output logic                   done,
    output logic [DIM*VAL_W-1:0]   quot_flat
);
    localparam int ELEM_W = (DIM > 1) ? $clog2(DIM) : 1;
    localparam int BIT_W  = $clog2(ACC_W);

    logic                    busy;
    logic [ELEM_W-1:0]       elem;
    logic [BIT_W-1:0]        bit_idx;
    logic [SUM_W-1:0]        rem_q;
    logic [ACC_W-1:0]        q_q, q_nx, mag;
    logic signed [ACC_W-1:0] cur, q_signed;
    logic [SUM_W:0]          rem_sh, rem_nx;
    logic                    neg, ge, last_bit, last_elem;

    // One restoring step on the current lane.
    always_comb begin
        cur       = $signed(num_flat[elem*ACC_W +: ACC_W]);
        neg       = cur[ACC_W-1];
        mag       = neg ? ACC_W'(-cur) : ACC_W'(cur);
        rem_sh    = {rem_q, mag[ACC_W-1-int'(bit_idx)]};
        ge        = rem_sh >= {1'b0, den};
        rem_nx    = ge ? (rem_sh - {1'b0, den}) : rem_sh;
        q_nx      = {q_q[ACC_W-2:0], ge};
        q_signed  = neg ? -$signed(q_nx) : $signed(q_nx);
        last_bit  = bit_idx == BIT_W'(ACC_W-1);
        last_elem = elem == ELEM_W'(DIM-1);
        done      = busy && last_bit && last_elem;
    end

    // Step counters, partial remainder and quotient, per-lane result store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            elem      <= '0;
            bit_idx   <= '0;
            rem_q     <= '0;
            q_q       <= '0;
            quot_flat <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            elem    <= '0;
            bit_idx <= '0;
            rem_q   <= '0;
            q_q     <= '0;
        end else if (busy) begin
            if (last_bit) begin
                quot_flat[elem*VAL_W +: VAL_W] <= VAL_W'(q_signed);
                rem_q   <= '0;
                q_q     <= '0;
                bit_idx <= '0;
                elem    <= last_elem ? '0 : elem + ELEM_W'(1);
                busy    <= !last_elem;
            end else begin
                rem_q   <= SUM_W'(rem_nx);
                q_q     <= q_nx;
                bit_idx <= bit_idx + BIT_W'(1);
            end
        end
    end
endmodule

// File: rtl/osm_attn_row.sv
// Streaming softmax attention for one row. It keeps a running maximum, a
// running weight sum and DIM accumulator lanes, and rescales them only when a
// score sets a new maximum. At end of row it divides each lane by the sum.
// Assumes at least one beat per row and a start marker on each row's first beat.
module osm_attn_row #(
    parameter int SCORE_W = 16,
    parameter int FRAC_W  = 8,
    parameter int VAL_W   = 16,
    parameter int DIM     = 4,
    parameter int ACC_W   = 40,
    parameter int SUM_W   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic                  in_sop,
    input  logic                  in_eop,
    input  logic [SCORE_W-1:0]    in_score,
    input  logic [DIM*VAL_W-1:0]  in_value,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [DIM*VAL_W-1:0]  out_vec,
    output logic [SCORE_W-1:0]    out_max,
    output logic [SUM_W-1:0]      out_sum
);
    import osm_pkg::*;
    localparam int MAG_W = SCORE_W + 1;
    localparam logic signed [SCORE_W-1:0] MAX_NEG = {1'b1, {(SCORE_W-1){1'b0}}};

    osm_state_e                st_q;
    logic signed [SCORE_W-1:0] m_q, m_eff;
    logic [SUM_W-1:0]          l_q, l_eff, l_nx;
    logic [SUM_W+15:0]         l_prod;
    logic signed [MAG_W-1:0]   x_x, m_x, diff;
    logic [MAG_W-1:0]          mag;
    logic [15:0]               w;
    logic                      fire, grow, div_done;
    logic signed [ACC_W-1:0]   acc_q [DIM];
    logic signed [ACC_W-1:0]   acc_eff [DIM];
    logic signed [ACC_W-1:0]   acc_nx [DIM];
    logic [DIM*ACC_W-1:0]      acc_flat;

    // Handshake and shared exponent argument; a start marker substitutes the reset state.
    always_comb begin
        in_ready  = st_q == ST_ACCUM;
        out_valid = st_q == ST_OUT;
        fire      = in_valid && in_ready;
        m_eff     = in_sop ? MAX_NEG : m_q;
        l_eff     = in_sop ? '0 : l_q;
        grow      = $signed(in_score) > m_eff;
        x_x       = {in_score[SCORE_W-1], in_score};
        m_x       = {m_eff[SCORE_W-1], m_eff};
        diff      = x_x - m_x;
        mag       = grow ? MAG_W'(diff) : MAG_W'(-diff);
        l_prod    = l_eff * w;
        l_nx      = grow ? (SUM_W'(l_prod >> W_FRAC) + SUM_W'(W_ONE)) : (l_eff + SUM_W'(w));
    end

    osm_exp2 #(.MAG_W(MAG_W), .FRAC_W(FRAC_W)) exp_i (.mag(mag), .weight(w));

    for (genvar k = 0; k < DIM; k++) begin : g_lane
        assign acc_eff[k] = in_sop ? '0 : acc_q[k];
        assign acc_flat[k*ACC_W +: ACC_W] = acc_q[k];
        osm_lane_upd #(.VAL_W(VAL_W), .ACC_W(ACC_W)) upd_i (
            .acc_in (acc_eff[k]),
            .val    (in_value[k*VAL_W +: VAL_W]),
            .w      (w),
            .grow   (grow),
            .acc_out(acc_nx[k])
        );
        // Register the lane on every accepted beat.
        always_ff @(posedge clk) begin
            if (!rst_n)    acc_q[k] <= '0;
            else if (fire) acc_q[k] <= acc_nx[k];
        end
    end

    // Running maximum and running sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q <= MAX_NEG;
            l_q <= '0;
        end else if (fire) begin
            m_q <= grow ? $signed(in_score) : m_eff;
            l_q <= l_nx;
        end
    end

    // Row sequencing: accumulate, divide, present.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_ACCUM;
        else begin
            case (st_q)
                ST_ACCUM: if (fire && in_eop) st_q <= ST_DIV;
                ST_DIV:   if (div_done)       st_q <= ST_OUT;
                default:  if (out_ready)      st_q <= ST_ACCUM;
            endcase
        end
    end

    osm_divider #(.DIM(DIM), .ACC_W(ACC_W), .SUM_W(SUM_W), .VAL_W(VAL_W)) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (fire && in_eop),
        .num_flat (acc_flat),
        .den      (l_q),
        .done     (div_done),
        .quot_flat(out_vec)
    );

    assign out_max = m_q;
    assign out_sum = l_q;
endmodule

// File: rtl/osm_attn_row_chk.sv
// Protocol and state checks for osm_attn_row, bound to every instance.
module osm_attn_row_chk #(
    parameter int SCORE_W = 16,
    parameter int VAL_W   = 16,
    parameter int DIM     = 4,
    parameter int ACC_W   = 40,
    parameter int SUM_W   = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 in_sop,
    input logic                 in_eop,
    input logic [SCORE_W-1:0]   in_score,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [DIM*VAL_W-1:0] out_vec,
    input logic [SCORE_W-1:0]   out_max,
    input logic [SUM_W-1:0]     out_sum
);
    localparam int LAT   = DIM * ACC_W;
    localparam int CNT_W = $clog2(LAT + 2) + 1;

    logic             fire;
    logic [CNT_W-1:0] wait_cnt;
    assign fire = in_valid && in_ready;

    // Count edges from end-of-row acceptance until the result is presented.
    always_ff @(posedge clk) begin
        if (!rst_n)                 wait_cnt <= '0;
        else if (fire && in_eop)    wait_cnt <= '0;
        else if (!out_valid && !in_ready) wait_cnt <= wait_cnt + CNT_W'(1);
    end

    AST_NO_INPUT_WHILE_PRESENTING: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R8
    AST_EOP_STALLS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && in_eop) |=> (!in_ready && !out_valid)); // R8
    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (wait_cnt == CNT_W'(LAT))); // R8
    AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_vec) && $stable(out_max) && $stable(out_sum))); // R9
    AST_MAX_COVERS_SCORE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ($signed(out_max) >= $signed($past(in_score)))); // R3
    AST_MAX_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !in_sop) |=> ($signed(out_max) >= $signed($past(out_max)))); // R3
    AST_SUM_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sum >= SUM_W'(32768))); // R5
endmodule

bind osm_attn_row osm_attn_row_chk #(
    .SCORE_W(SCORE_W), .VAL_W(VAL_W), .DIM(DIM), .ACC_W(ACC_W), .SUM_W(SUM_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_eop(in_eop), .in_score(in_score),
    .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec),
    .out_max(out_max), .out_sum(out_sum)
);

// File: tb/osm_attn_row_tb_top.sv
// Scoreboard bench: the driver models each row and queues the expectation,
// and the monitor pops and compares when the block presents a result.
module osm_attn_row_tb_top;
    localparam int SCORE_W = 16, FRAC_W = 8, VAL_W = 16, DIM = 4, ACC_W = 40, SUM_W = 32;
    localparam int LAT = DIM * ACC_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, out_ready = 1'b0;
    logic [SCORE_W-1:0] in_score = '0;
    logic [DIM*VAL_W-1:0] in_value = '0;
    logic in_ready, out_valid;
    logic [DIM*VAL_W-1:0] out_vec;
    logic [SCORE_W-1:0] out_max;
    logic [SUM_W-1:0] out_sum;

    always #5 clk = ~clk;

    osm_attn_row #(.SCORE_W(SCORE_W), .FRAC_W(FRAC_W), .VAL_W(VAL_W), .DIM(DIM),
                   .ACC_W(ACC_W), .SUM_W(SUM_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sop(in_sop), .in_eop(in_eop), .in_score(in_score), .in_value(in_value),
        .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec),
        .out_max(out_max), .out_sum(out_sum)
    );

    typedef struct {
        int     v [DIM];
        int     mx;
        longint sm;
        int     r [DIM];
        longint rs;
        int     maxabs;
        bit     exact;
        bit     stall;
    } exp_t;

    exp_t   exp_q [$];
    int     eop_q [$];
    int     errors = 0, checks = 0, rows_done = 0, cyc = 0;
    int     knot [0:8];
    int     row_n;
    int     row_s [0:15];
    int     row_v [0:15][0:DIM-1];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // R4 weight as stated in the requirement.
    function automatic longint e2(input longint d);
        longint n, ip, f, s, t, y;
        n  = -d;
        ip = n >> FRAC_W;
        f  = n & ((1 << FRAC_W) - 1);
        s  = f >> (FRAC_W - 3);
        t  = f & ((1 << (FRAC_W - 3)) - 1);
        y  = knot[s] - (((knot[s] - knot[s+1]) * t) >> (FRAC_W - 3));
        return (ip >= 16) ? 0 : (y >> ip);
    endfunction

    function automatic int lane_cut(input longint q);
        logic signed [VAL_W-1:0] c;
        c = VAL_W'(q);
        return int'(c);
    endfunction

    // Build the expectation (online R5/R6 model plus two-pass R10 reference) and drive the row.
    task automatic run_row(input bit exact, input bit stall);
        exp_t   e;
        longint m, l, w, big, rl;
        longint acc [DIM];
        longint ra [DIM];
        m = -32768; l = 0; big = -32768; rl = 0; e.maxabs = 0;
        for (int k = 0; k < DIM; k++) begin acc[k] = 0; ra[k] = 0; end
        for (int j = 0; j < row_n; j++) begin
            if (row_s[j] > m) begin
                w = e2(m - row_s[j]);
                l = ((l * w) >>> 15) + 32768;
                for (int k = 0; k < DIM; k++) acc[k] = ((acc[k] * w) >>> 15) + longint'(row_v[j][k]) * 32768;
                m = row_s[j];
            end else begin
                w = e2(row_s[j] - m);
                l = l + w;
                for (int k = 0; k < DIM; k++) acc[k] = acc[k] + longint'(row_v[j][k]) * w;
            end
            if (row_s[j] > big) big = row_s[j];
            for (int k = 0; k < DIM; k++)
                if ((row_v[j][k] < 0 ? -row_v[j][k] : row_v[j][k]) > e.maxabs)
                    e.maxabs = (row_v[j][k] < 0) ? -row_v[j][k] : row_v[j][k];
        end
        for (int j = 0; j < row_n; j++) begin
            w = e2(row_s[j] - big);
            rl = rl + w;
            for (int k = 0; k < DIM; k++) ra[k] = ra[k] + longint'(row_v[j][k]) * w;
        end
        for (int k = 0; k < DIM; k++) begin
            e.v[k] = lane_cut(acc[k] / l);
            e.r[k] = lane_cut(ra[k] / rl);
        end
        e.mx = int'(m); e.sm = l; e.rs = rl; e.exact = exact; e.stall = stall;
        exp_q.push_back(e);
        for (int j = 0; j < row_n; j++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = (j == 0);
            in_eop   = (j == row_n - 1);
            in_score = SCORE_W'(row_s[j]);
            for (int k = 0; k < DIM; k++) in_value[k*VAL_W +: VAL_W] = VAL_W'(row_v[j][k]);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        eop_q.push_back(cyc);
        check(in_ready == 1'b0, "R8", "in_ready after end of row", longint'(in_ready), 0);
    endtask

    // Monitor: latency, exact model, two-pass reference, hold under stall.
    initial begin
        forever begin
            @(negedge clk);
            if (out_valid) begin
                exp_t e;
                int   ecyc, tol;
                logic [DIM*VAL_W-1:0] hv;
                logic [SUM_W-1:0] hs;
                logic [SCORE_W-1:0] hm;
                if (exp_q.size() == 0 || eop_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected output", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    ecyc = eop_q.pop_front();
                    check(cyc - ecyc == LAT, "R8", "result latency", cyc - ecyc, LAT);
                    check($signed(out_max) == e.mx, "R3", "row max", $signed(out_max), e.mx);
                    check(longint'(out_sum) == e.sm, "R5", "row sum", longint'(out_sum), e.sm);
                    for (int k = 0; k < DIM; k++) begin
                        int a;
                        a = int'($signed(out_vec[k*VAL_W +: VAL_W]));
                        check(a == e.v[k], "R7", $sformatf("lane %0d (R12 packing)", k), a, e.v[k]);
                        tol = e.exact ? 0 : 2 + e.maxabs / 64;
                        check((a - e.r[k] <= tol) && (e.r[k] - a <= tol), "R10",
                              $sformatf("lane %0d vs two-pass", k), a, e.r[k]);
                    end
                    if (e.exact)
                        check(longint'(out_sum) == e.rs, "R10", "sum vs two-pass", longint'(out_sum), e.rs);
                    if (e.stall) begin
                        hv = out_vec; hs = out_sum; hm = out_max;
                        repeat (5) begin
                            @(negedge clk);
                            check(out_valid && out_vec == hv && out_sum == hs && out_max == hm,
                                  "R9", "output held during stall", longint'(out_sum), longint'(hs));
                        end
                    end
                end
                out_ready = 1'b1;
                @(negedge clk);
                out_ready = 1'b0;
                rows_done++;
            end
        end
    end

    task automatic finish_up();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d rows expected=%0d rows", rows_done, 9);
        finish_up();
    end

    initial begin
        int seed;
        for (int k = 0; k <= 8; k++) knot[k] = $rtoi($floor(32768.0 * $pow(2.0, -k / 8.0) + 0.5));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1", "in_ready after reset", longint'(in_ready), 1);
        check(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);

        // R11: one element returns its values.
        row_n = 1; row_s[0] = 384;
        row_v[0] = '{100, -200, 300, -400};
        run_row(1'b1, 1'b0);

        // R6: descending scores, no rescale, exact against two-pass.
        row_n = 5;
        row_s[0] = 512; row_s[1] = 256; row_s[2] = 0; row_s[3] = -128; row_s[4] = -700;
        for (int j = 0; j < 5; j++) row_v[j] = '{10 * j + 3, -50 + j, 700 - 90 * j, j * j};
        run_row(1'b1, 1'b0);

        // R5: ascending scores, rescale on every beat.
        row_n = 5;
        row_s[0] = -300; row_s[1] = -100; row_s[2] = 50; row_s[3] = 200; row_s[4] = 600;
        for (int j = 0; j < 5; j++) row_v[j] = '{-400 + 150 * j, 900 - 200 * j, 37 * j, -3};
        run_row(1'b0, 1'b0);

        // R6: ties with the maximum are not new maxima; R9 stall on this row.
        row_n = 7;
        row_s[0] = 100; row_s[1] = 300; row_s[2] = 300; row_s[3] = -50;
        row_s[4] = 300; row_s[5] = 1000; row_s[6] = 20;
        for (int j = 0; j < 7; j++) row_v[j] = '{50 * j - 100, 333, -20 * j, 7 * j + 1};
        run_row(1'b0, 1'b1);

        // R2: new row with lower scores than the previous row's maximum.
        row_n = 2; row_s[0] = -1000; row_s[1] = -2000;
        row_v[0] = '{11, 22, 33, 44}; row_v[1] = '{-11, -22, -33, -44};
        run_row(1'b1, 1'b0);

        // R4: a 20.0 gap makes the earlier weight zero; output is the last vector.
        row_n = 2; row_s[0] = 0; row_s[1] = 20 * 256;
        row_v[0] = '{9999, -9999, 5000, 1}; row_v[1] = '{7, -7, 1234, -1};
        run_row(1'b1, 1'b0);

        // R7: truncation toward zero on negative quotients, full negative range.
        row_n = 3; row_s[0] = 0; row_s[1] = 0; row_s[2] = 0;
        row_v[0] = '{-1, -2, 5, -32768}; row_v[1] = '{-1, -2, 5, -32768}; row_v[2] = '{0, -3, 6, -32768};
        run_row(1'b1, 1'b0);

        // R10: longer mixed row from a fixed pseudo-random sequence.
        seed = 12345; row_n = 12;
        for (int j = 0; j < 12; j++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            row_s[j] = (seed % 4001) - 2000;
            for (int k = 0; k < DIM; k++) begin
                seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
                row_v[j][k] = (seed % 2001) - 1000;
            end
        end
        run_row(1'b0, 1'b0);

        // R2: sop resets after a large-valued row.
        row_n = 1; row_s[0] = -32768;
        row_v[0] = '{1, 2, 3, 4};
        run_row(1'b1, 1'b0);

        while (rows_done < 9) @(negedge clk);
        repeat (2) @(negedge clk);
        finish_up();
    end
endmodule